// File: doc/BRIEF.md
# Bus Mode Detect and Termination Enable Controller

This controller decides the operating mode of a differential bus terminator and whether its termination switches may close. Three comparator flags, already synchronized to the system clock, report where the sense line sits: below the low threshold (single-ended bus), inside the low-voltage differential window, or above the high threshold (high-voltage differential bus). A reading counts as valid only when exactly one flag is set. A new reading becomes the committed mode only after it has held without interruption for a programmable number of millisecond ticks. The default of 200 ticks gives a delay of about 200 ms, which sits inside the 100 to 310 ms window a bus-mode change must respect.

The committed mode is shown on three one-hot status outputs. The termination switches are enabled only when the committed mode is the low-voltage differential one and the disconnect input, after its own synchronizer, is low. A single-cycle pulse tells the trim register to reload its nominal impedance and bias settings. This pulse fires once after reset is released and again each time the disconnect input falls.

Top module: `bus_mode_ctrl`

## Requirements
- R1: After reset, and until a first mode is committed, se_o is 1, lvd_o and hvd_o are 0, and term_en_o is 0.
- R2: At all times exactly one of se_o, lvd_o and hvd_o is 1.
- R3: A valid reading maps to a mode as follows: below_lo_i alone means single-ended (se_o), lvd_win_i alone means low-voltage differential (lvd_o), and above_hi_i alone means high-voltage differential (hvd_o). The reading is committed on the DELAY_MS-th ms_tick_i that follows the first clock cycle in which it appeared, provided it stays steady throughout.
- R4: The committed mode changes only in a cycle with ms_tick_i high, never before DELAY_MS ticks of a steady reading. A different valid reading restarts the count from zero.
- R5: A reading with no flag set, or with more than one flag set, keeps the committed mode and discards any count in progress.
- R6: term_en_o is 1 only when a mode has been committed, that mode is low-voltage differential, and the synchronized disconnect is low. In single-ended and high-voltage differential modes it is 0.
- R7: disc_i passes through SYNC_STAGES flip-flops. A change on disc_i reaches term_en_o on the SYNC_STAGES-th rising clock edge after the change, and not earlier.
- R8: trim_reload_o is high for exactly one clock cycle, in the first cycle after reset is released.
- R9: Each falling edge of disc_i produces exactly one single-cycle pulse on trim_reload_o. A rising edge produces none.
- R10: While a different reading is pending, a valid reading equal to the committed mode cancels it. A later attempt then needs the full DELAY_MS ticks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| below_lo_i | input | 1 | Sense level below the single-ended threshold |
| lvd_win_i | input | 1 | Sense level within the low-voltage differential window |
| above_hi_i | input | 1 | Sense level above the high-voltage threshold |
| disc_i | input | 1 | Disconnect request; high forces termination off (asynchronous) |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| se_o | output | 1 | Committed mode is single-ended |
| lvd_o | output | 1 | Committed mode is low-voltage differential |
| hvd_o | output | 1 | Committed mode is high-voltage differential |
| term_en_o | output | 1 | Close the termination switches |
| trim_reload_o | output | 1 | One-cycle pulse to restore trim defaults |

## Verification
The bench builds the block with DELAY_MS set to 4 and SYNC_STAGES left at 2. It drives the tick input itself, so a whole qualification delay costs a handful of cycles. With the delay this short, the one-tick-early boundary, restarts after an interruption, invalid readings and cancellation by the committed reading can all be walked in short sequences. The two-stage synchronizer lets the bench check cycle by cycle when the disconnect input first reaches the enable and when the reload pulse appears.

// File: rtl/bus_mode_pkg.sv
// Shared types for the bus mode controller.
// Assumes: the encoding is internal; outputs are decoded one-hot.
package bus_mode_pkg;
    typedef enum logic [1:0] {
        MODE_SE  = 2'd0,
        MODE_LVD = 2'd1,
        MODE_HVD = 2'd2
    } bus_mode_e;
endpackage

// File: rtl/bm_sense_classify.sv
// Turns the three comparator flags into a candidate mode.
// Assumes: flags are already synchronized; a reading is valid only when
// exactly one flag is set.
module bm_sense_classify
    import bus_mode_pkg::*;
(
    input  logic      below_lo_i,
    input  logic      lvd_win_i,
    input  logic      above_hi_i,
    output bus_mode_e raw_mode_o,
    output logic      raw_vld_o
);
    logic [1:0] flag_sum;

    // Count the set flags so that overlaps and gaps are rejected.
    always_comb begin
        flag_sum = {1'b0, below_lo_i} + {1'b0, lvd_win_i} + {1'b0, above_hi_i};
        raw_vld_o = (flag_sum == 2'd1);
    end

    // Map the single set flag to a mode; the value is unused when invalid.
    always_comb begin
        if (above_hi_i)      raw_mode_o = MODE_HVD;
        else if (lvd_win_i)  raw_mode_o = MODE_LVD;
        else                 raw_mode_o = MODE_SE;
    end
endmodule

// File: rtl/bm_mode_qualify.sv
// Commits a candidate mode once it has been steady for DELAY_MS ticks.
// Assumes: ms_tick_i is a one-cycle pulse; DELAY_MS is at least 1.
module bm_mode_qualify
    import bus_mode_pkg::*;
#(
    parameter int DELAY_MS = 200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e raw_mode_i,
    input  logic      raw_vld_i,
    input  logic      ms_tick_i,
    output bus_mode_e mode_o,
    output logic      locked_o
);
    localparam int CNT_W = (DELAY_MS < 2) ? 1 : $clog2(DELAY_MS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_MS - 1);

    bus_mode_e        mode_q;
    bus_mode_e        cand_q;
    logic             locked_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    // Track the pending candidate, count ticks and commit on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_SE;
            cand_q   <= MODE_SE;
            locked_q <= 1'b0;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
        end else if (!raw_vld_i) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (locked_q && (raw_mode_i == mode_q)) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!pend_q || (raw_mode_i != cand_q)) begin
            cand_q <= raw_mode_i;
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (ms_tick_i) begin
            if (cnt_q == LAST) begin
                mode_q   <= cand_q;
                locked_q <= 1'b1;
                pend_q   <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign mode_o   = mode_q;
    assign locked_o = locked_q;
endmodule

// File: rtl/bm_disc_ctrl.sv
// Synchronizes the disconnect input and makes the trim-reload pulse.
// Assumes: disc_i is asynchronous; the pulse fires once after reset and on
// every falling edge of the synchronized disconnect.
module bm_disc_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disc_i,
    output logic disc_sync_o,
    output logic reload_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   boot_q;
    logic                   reload_q;

    // Synchronizer chain, one flop per stage.
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // First stage samples the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= disc_i;
            end
        end else begin : g_next
            // Later stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Edge detection and the one-cycle reload pulse (boot or disc fall).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            boot_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            prev_q   <= sync_q[SYNC_STAGES-1];
            boot_q   <= 1'b1;
            reload_q <= !boot_q || (prev_q && !sync_q[SYNC_STAGES-1]);
        end
    end

    assign disc_sync_o = sync_q[SYNC_STAGES-1];
    assign reload_o    = reload_q;
endmodule

// File: rtl/bus_mode_ctrl.sv
// Top of the bus mode controller: classify, qualify, gate termination.
// Assumes: comparator flags synchronous to clk; ms_tick_i one cycle wide.
module bus_mode_ctrl
    import bus_mode_pkg::*;
#(
    parameter int DELAY_MS    = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo_i,
    input  logic lvd_win_i,
    input  logic above_hi_i,
    input  logic disc_i,
    input  logic ms_tick_i,
    output logic se_o,
    output logic lvd_o,
    output logic hvd_o,
    output logic term_en_o,
    output logic trim_reload_o
);
    bus_mode_e raw_mode;
    logic      raw_vld;
    bus_mode_e mode;
    logic      locked;
    logic      disc_sync;

    bm_sense_classify u_cls (
        .below_lo_i (below_lo_i),
        .lvd_win_i  (lvd_win_i),
        .above_hi_i (above_hi_i),
        .raw_mode_o (raw_mode),
        .raw_vld_o  (raw_vld)
    );

    bm_mode_qualify #(.DELAY_MS(DELAY_MS)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_mode_i (raw_mode),
        .raw_vld_i  (raw_vld),
        .ms_tick_i  (ms_tick_i),
        .mode_o     (mode),
        .locked_o   (locked)
    );

    bm_disc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_disc (
        .clk         (clk),
        .rst_n       (rst_n),
        .disc_i      (disc_i),
        .disc_sync_o (disc_sync),
        .reload_o    (trim_reload_o)
    );

    // Decode status lines and gate the termination switches.
    always_comb begin
        se_o      = (mode == MODE_SE);
        lvd_o     = (mode == MODE_LVD);
        hvd_o     = (mode == MODE_HVD);
        term_en_o = locked && (mode == MODE_LVD) && !disc_sync;
    end
endmodule

// File: rtl/bus_mode_ctrl_chk.sv
// Checker for bus_mode_ctrl, attached by bind.
module bus_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ms_tick_i,
    input logic se_o,
    input logic lvd_o,
    input logic hvd_o,
    input logic term_en_o,
    input logic trim_reload_o
);
    // R2
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({se_o, lvd_o, hvd_o}) == 1);

    // R6
    term_only_lvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_en_o |-> lvd_o);

    // R4
    mode_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_tick_i |=> $stable({se_o, lvd_o, hvd_o}));

    // R9
    reload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trim_reload_o |=> !trim_reload_o);

    // R6
    term_rise_lvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_en_o) |-> lvd_o && !se_o && !hvd_o);
endmodule

bind bus_mode_ctrl bus_mode_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ms_tick_i     (ms_tick_i),
    .se_o          (se_o),
    .lvd_o         (lvd_o),
    .hvd_o         (hvd_o),
    .term_en_o     (term_en_o),
    .trim_reload_o (trim_reload_o)
);

// File: tb/sim_bus_mode_ctrl.sv
module sim_bus_mode_ctrl;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_lo_i = 1'b0, lvd_win_i = 1'b0, above_hi_i = 1'b0;
    logic disc_i = 1'b0, ms_tick_i = 1'b0;
    logic se_o, lvd_o, hvd_o, term_en_o, trim_reload_o;

    int total = 0;
    int bad = 0;
    int rl_cnt = 0;

    always #4 clk = ~clk;

    bus_mode_ctrl #(.DELAY_MS(DLY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .below_lo_i(below_lo_i), .lvd_win_i(lvd_win_i), .above_hi_i(above_hi_i),
        .disc_i(disc_i), .ms_tick_i(ms_tick_i),
        .se_o(se_o), .lvd_o(lvd_o), .hvd_o(hvd_o),
        .term_en_o(term_en_o), .trim_reload_o(trim_reload_o)
    );

    // Count reload pulses seen away from the clock edge.
    always @(negedge clk) if (rst_n && trim_reload_o) rl_cnt++;

    // Vector: {flags{above,win,below}[2:0], disc, ticks[3:0], exp{se,lvd,hvd,term}[3:0]}
    localparam int NV = 15;
    localparam logic [11:0] VEC [NV] = '{
        {3'b010, 1'b0, 4'd3, 4'b1000},  // R4 one tick short
        {3'b010, 1'b0, 4'd1, 4'b0101},  // R3 LVD committed
        {3'b100, 1'b0, 4'd3, 4'b0101},  // R4 HVD pending
        {3'b000, 1'b0, 4'd2, 4'b0101},  // R5 gap clears count
        {3'b100, 1'b0, 4'd3, 4'b0101},  // R4 restarted
        {3'b100, 1'b0, 4'd1, 4'b0010},  // R3 HVD, R6 off
        {3'b011, 1'b0, 4'd5, 4'b0010},  // R5 overlap holds
        {3'b001, 1'b0, 4'd4, 4'b1000},  // R3 SE, R6 off
        {3'b010, 1'b1, 4'd4, 4'b0100},  // R6 disconnect blocks
        {3'b010, 1'b0, 4'd0, 4'b0101},  // R6 reconnect enables
        {3'b001, 1'b0, 4'd2, 4'b0101},  // R10 SE pending
        {3'b010, 1'b0, 4'd0, 4'b0101},  // R10 cancel
        {3'b001, 1'b0, 4'd3, 4'b0101},  // R10 full delay again
        {3'b001, 1'b0, 4'd1, 4'b1000},  // R10 SE committed
        {3'b100, 1'b0, 4'd4, 4'b0010}   // R3 HVD from SE
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        ms_tick_i = 1'b1;
        @(negedge clk);
        ms_tick_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_flags(input logic [2:0] f);
        {above_hi_i, lvd_win_i, below_lo_i} = f;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int base;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check("R1", {se_o, lvd_o, hvd_o, term_en_o}, 4'b1000);
        cycles(4);
        // R8 exactly one boot pulse
        check("R8", rl_cnt, 1);
        check("R1 no commit without reading", {se_o, lvd_o, hvd_o, term_en_o}, 4'b1000);

        for (int v = 0; v < NV; v++) begin
            set_flags(VEC[v][11:9]);
            disc_i = VEC[v][8];
            cycles(1);
            for (int t = 0; t < int'(VEC[v][7:4]); t++) tick();
            cycles(4);
            check($sformatf("R3/R4/R5/R6/R10 vec%0d", v),
                  {se_o, lvd_o, hvd_o, term_en_o}, VEC[v][3:0]);
        end

        // R7 latency: commit LVD, then raise disconnect.
        set_flags(3'b010);
        cycles(1);
        for (int t = 0; t < DLY; t++) tick();
        cycles(3);
        check("R7 enabled before", term_en_o, 1);
        disc_i = 1'b1;
        cycles(1);
        check("R7 one edge still on", term_en_o, 1);
        cycles(1);
        check("R7 off at second edge", term_en_o, 0);

        // R9 rising edge gives no pulse, falling gives exactly one.
        cycles(4);
        base = rl_cnt;
        cycles(6);
        check("R9 no pulse on rise", rl_cnt - base, 0);
        base = rl_cnt;
        disc_i = 1'b0;
        cycles(8);
        check("R9 one pulse on fall", rl_cnt - base, 1);
        check("R7 re-enabled", term_en_o, 1);

        // R8 reset again gives a single new pulse and the R1 state.
        rst_n = 1'b0;
        cycles(2);
        base = rl_cnt;
        rst_n = 1'b1;
        cycles(1);
        check("R1 after re-reset", {se_o, lvd_o, hvd_o, term_en_o}, 4'b1000);
        cycles(5);
        check("R8 single pulse after re-reset", rl_cnt - base, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule